// File: doc/BRIEF.md
# Split-Timing L1 Data Cache Tag Lookup

This block holds the tag and state of a 64-set, 8-way L1 data cache with 64-byte lines. A lookup begins with a virtual address. The set index and the line offset sit entirely inside the 4 KB page offset, so they need no translation. The block therefore starts reading the selected set straight away, while the address translation unit is still working. One cycle later, or after a longer wait if translation is slow, the physical page number arrives on a separate strobe port. That 40-bit number is compared with the stored tags of all eight ways. The result is a hit with its way number and payload, or a miss with a suggested victim way.

Refills come in through a fill port, which names the set, the way, the tag and a small payload word that stands in for the line data. A flush input invalidates the whole cache in one cycle. Line data, coherence and the lower levels of the memory hierarchy live elsewhere.

Top module: `vipt_tag_lookup`

## Requirements
- R1: After reset, resp_valid is 0, req_ready is 1, every way of every set is invalid, and every replacement pointer is 0.
- R2: The set is chosen from req_vaddr[11:6]. The line offset req_vaddr[5:0] and all virtual bits above bit 11 have no effect on the result.
- R3: The stored tag is compared only with xlat_ppn. A lookup whose xlat_ppn differs from the stored tag misses, even when the virtual address is identical to the one that hit.
- R4: A request is accepted on a clock edge where req_valid and req_ready are both 1. Its result appears with resp_valid=1 for exactly one cycle, right after the edge where the request is pending and xlat_valid is 1.
- R5: While a request waits and xlat_valid is 0, req_ready is 0 and resp_valid stays 0. The request is kept until translation arrives.
- R6: A hit needs both the way's valid bit and an equal tag. resp_hit is then 1, resp_way gives the way that matched, and resp_data gives that way's payload. At most one way may match.
- R7: On a miss, resp_hit is 0 and resp_way names the lowest-numbered invalid way of the set, if the set has one.
- R8: On a miss in a set where all ways are valid, resp_way is that set's 3-bit replacement pointer. The pointer advances by one, modulo 8, on each fill into that set while all its ways were valid. Each set has its own pointer.
- R9: A flush clears every valid bit in one cycle. A fill in the same cycle as a flush is discarded.
- R10: A fill writes the tag and payload of the named set and way and marks that way valid. No other set or way is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every line |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 48 | Virtual address of the lookup |
| req_ready | output | 1 | The block can accept a request in this cycle |
| xlat_valid | input | 1 | Translated page number is present |
| xlat_ppn | input | 40 | Physical page number, used as the tag |
| fill_valid | input | 1 | Refill write strobe |
| fill_set | input | 6 | Set written by the refill |
| fill_way | input | 3 | Way written by the refill |
| fill_tag | input | 40 | Tag written by the refill |
| fill_data | input | 16 | Payload word written by the refill |
| resp_valid | output | 1 | Lookup result is present (one cycle) |
| resp_hit | output | 1 | 1 on a hit, 0 on a miss |
| resp_way | output | 3 | Way that hit, or the suggested victim on a miss |
| resp_data | output | 16 | Payload of the way that hit, 0 on a miss |

## Verification
Each result is due on the clock edge that follows the first rising edge at which a request is pending and xlat_valid is high. The bench drives inputs on falling edges and reads resp_* on the falling edge right after that compare edge. While translation is held back, the bench checks at every falling edge that req_ready and resp_valid are both low. Fills and flushes are issued one falling edge before the next request. As a result, the tag read and the valid bits seen by each compare already include them, and the expected hit, way and payload follow directly from the sequence of fills.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  localparam int unsigned D_SETS  = 64;
  localparam int unsigned D_WAYS  = 8;
  localparam int unsigned D_OFF_W = 6;
  localparam int unsigned D_PG_W  = 12;
  localparam int unsigned D_VA_W  = 48;
  localparam int unsigned D_PA_W  = 52;
  localparam int unsigned D_PAY_W = 16;

  typedef enum logic {
    S1_EMPTY   = 1'b0,
    S1_PENDING = 1'b1
  } s1_state_e;

endpackage

// File: rtl/vipt_tag_ram.sv
module vipt_tag_ram #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 40,
  parameter int unsigned PAY_W = 16,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned ENT_W = TAG_W + PAY_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [TAG_W-1:0] wtag,
  input  logic [PAY_W-1:0] wpay,
  input  logic [IDX_W-1:0] raddr,
  output logic [TAG_W-1:0] rtag,
  output logic [PAY_W-1:0] rpay
);

  logic [ENT_W-1:0] mem [SETS];
  logic [ENT_W-1:0] rd_q;

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= {wtag, wpay};
    end
    rd_q <= mem[raddr];
  end

  assign rtag = rd_q[ENT_W-1:PAY_W];
  assign rpay = rd_q[PAY_W-1:0];

endmodule

// File: rtl/vipt_valid_bits.sv
module vipt_valid_bits #(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_row,
  output logic [WAYS-1:0]  fill_row
);

  // kept in flops so that a flush can clear all of them in a single cycle
  logic [WAYS-1:0] vld_q [SETS];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < int'(SETS); s++) begin
        vld_q[s] <= '0;
      end
    end else if (fill_en) begin
      vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  assign rd_row   = vld_q[rd_set];
  assign fill_row = vld_q[fill_set];

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 40,
  parameter int unsigned PAY_W = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS*PAY_W-1:0] pays,
  input  logic [WAYS-1:0]       vld_row,
  input  logic [TAG_W-1:0]      ppn,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [PAY_W-1:0]      hit_pay
);

  for (genvar w = 0; w < int'(WAYS); w++) begin : g_cmp
    assign hit_vec[w] = vld_row[w] && (tags[w*TAG_W +: TAG_W] == ppn);
  end

  // OR-based encoder: correct as long as no more than one way matches
  always_comb begin
    hit_way = '0;
    hit_pay = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (hit_vec[w]) begin
        hit_way = hit_way | WAY_W'(w);
        hit_pay = hit_pay | pays[w*PAY_W +: PAY_W];
      end
    end
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/vipt_victim_pick.sv
module vipt_victim_pick #(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAYS-1:0]  fill_row,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [WAYS-1:0]  rd_row,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic             found;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(SETS); s++) begin
        ptr_q[s] <= '0;
      end
    end else if (fill_en && (&fill_row)) begin
      ptr_q[fill_set] <= ptr_q[fill_set] + 1'b1;
    end
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (!found && !rd_row[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      victim = ptr_q[rd_set];
    end
  end

endmodule

// File: rtl/vipt_tag_lookup.sv
module vipt_tag_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned SETS  = D_SETS,
  parameter int unsigned WAYS  = D_WAYS,
  parameter int unsigned OFF_W = D_OFF_W,
  parameter int unsigned PG_W  = D_PG_W,
  parameter int unsigned VA_W  = D_VA_W,
  parameter int unsigned PA_W  = D_PA_W,
  parameter int unsigned PAY_W = D_PAY_W,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned TAG_W = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  input  logic             xlat_valid,
  input  logic [TAG_W-1:0] xlat_ppn,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PAY_W-1:0] fill_data,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [WAY_W-1:0] resp_way,
  output logic [PAY_W-1:0] resp_data
);

  s1_state_e        s1_st;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_pending;
  logic             accept;
  logic             fire;
  logic             fill_en;
  logic [IDX_W-1:0] rd_addr;

  logic [WAYS*TAG_W-1:0] rtag_flat;
  logic [WAYS*PAY_W-1:0] rpay_flat;
  logic [WAYS-1:0]       vld_rd_row;
  logic [WAYS-1:0]       vld_fill_row;
  logic [WAYS-1:0]       hit_vec;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;
  logic [PAY_W-1:0]      hit_pay;
  logic [WAY_W-1:0]      victim;

  assign s1_pending = (s1_st == S1_PENDING);
  assign req_ready  = !s1_pending || xlat_valid;
  assign accept     = req_valid && req_ready;
  assign fire       = s1_pending && xlat_valid;
  assign fill_en    = fill_valid && !flush;

  // the index comes from bits that lie inside the page offset, so no translation is needed
  assign rd_addr = accept ? req_vaddr[OFF_W +: IDX_W] : s1_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_st  <= S1_EMPTY;
      s1_idx <= '0;
    end else begin
      if (accept) begin
        s1_st  <= S1_PENDING;
        s1_idx <= req_vaddr[OFF_W +: IDX_W];
      end else if (fire) begin
        s1_st <= S1_EMPTY;
      end
    end
  end

  for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
    logic we_w;
    assign we_w = fill_en && (fill_way == WAY_W'(w));
    vipt_tag_ram #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .PAY_W (PAY_W)
    ) ram_i (
      .clk   (clk),
      .we    (we_w),
      .waddr (fill_set),
      .wtag  (fill_tag),
      .wpay  (fill_data),
      .raddr (rd_addr),
      .rtag  (rtag_flat[w*TAG_W +: TAG_W]),
      .rpay  (rpay_flat[w*PAY_W +: PAY_W])
    );
  end

  vipt_valid_bits #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) vld_i (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .fill_en  (fill_en),
    .fill_set (fill_set),
    .fill_way (fill_way),
    .rd_set   (s1_idx),
    .rd_row   (vld_rd_row),
    .fill_row (vld_fill_row)
  );

  vipt_way_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .PAY_W (PAY_W)
  ) match_i (
    .tags    (rtag_flat),
    .pays    (rpay_flat),
    .vld_row (vld_rd_row),
    .ppn     (xlat_ppn),
    .hit_vec (hit_vec),
    .hit     (hit),
    .hit_way (hit_way),
    .hit_pay (hit_pay)
  );

  vipt_victim_pick #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) victim_i (
    .clk      (clk),
    .rst      (rst),
    .fill_en  (fill_en),
    .fill_set (fill_set),
    .fill_row (vld_fill_row),
    .rd_set   (s1_idx),
    .rd_row   (vld_rd_row),
    .victim   (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      resp_data  <= '0;
    end else begin
      resp_valid <= fire;
      if (fire) begin
        resp_hit  <= hit;
        resp_way  <= hit ? hit_way : victim;
        resp_data <= hit ? hit_pay : '0;
      end
    end
  end

endmodule

// File: rtl/vipt_tag_lookup_chk.sv
module vipt_tag_lookup_chk #(
  parameter int unsigned WAYS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            s1_pending,
  input logic            xlat_valid,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic [WAYS-1:0] hit_vec
);

  p_resp_follows_xlat_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_pending && xlat_valid) |=> resp_valid);

  p_no_spurious_resp_r4: assert property (@(posedge clk) disable iff (rst)
    !(s1_pending && xlat_valid) |=> !resp_valid);

  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_pending && !xlat_valid) |-> !req_ready);

  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  p_hit_has_resp_r6: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid || $stable(resp_hit));

  p_flush_misses_r9: assert property (@(posedge clk) disable iff (rst)
    flush ##1 (s1_pending && xlat_valid) |=> !resp_hit);

endmodule

bind vipt_tag_lookup vipt_tag_lookup_chk #(.WAYS(WAYS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .s1_pending (s1_pending),
  .xlat_valid (xlat_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .hit_vec    (hit_vec)
);

// File: tb/vipt_tag_lookup_tb_top.sv
module vipt_tag_lookup_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        flush;
  logic        req_valid;
  logic [47:0] req_vaddr;
  logic        req_ready;
  logic        xlat_valid;
  logic [39:0] xlat_ppn;
  logic        fill_valid;
  logic [5:0]  fill_set;
  logic [2:0]  fill_way;
  logic [39:0] fill_tag;
  logic [15:0] fill_data;
  logic        resp_valid;
  logic        resp_hit;
  logic [2:0]  resp_way;
  logic [15:0] resp_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  vipt_tag_lookup dut_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_ready  (req_ready),
    .xlat_valid (xlat_valid),
    .xlat_ppn   (xlat_ppn),
    .fill_valid (fill_valid),
    .fill_set   (fill_set),
    .fill_way   (fill_way),
    .fill_tag   (fill_tag),
    .fill_data  (fill_data),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_way   (resp_way),
    .resp_data  (resp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_va(input logic [35:0] hi, input logic [5:0] idx, input logic [5:0] off);
    return {hi, idx, off};
  endfunction

  task automatic do_fill(input logic [5:0] s, input logic [2:0] w, input logic [39:0] t,
                         input logic [15:0] d, input bit with_flush);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = s; fill_way = w; fill_tag = t; fill_data = d;
    flush = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic do_lookup(input logic [47:0] va, input logic [39:0] ppn, input int lat,
                           output logic hit, output logic [2:0] way, output logic [15:0] pay);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk(req_ready == 1'b0, "R5 ready low while waiting", 64'(req_ready), 64'd0);
      chk(resp_valid == 1'b0, "R5 no response while waiting", 64'(resp_valid), 64'd0);
      @(negedge clk);
    end
    xlat_valid = 1'b1; xlat_ppn = ppn;
    @(negedge clk);
    xlat_valid = 1'b0;
    chk(resp_valid == 1'b1, "R4 response after translation", 64'(resp_valid), 64'd1);
    hit = resp_hit; way = resp_way; pay = resp_data;
  endtask

  task automatic t_reset();
    logic h; logic [2:0] w; logic [15:0] d;
    chk(resp_valid == 1'b0, "R1 resp_valid after reset", 64'(resp_valid), 64'd0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    do_lookup(mk_va(36'h1, 6'd0, 6'd0), 40'h0, 0, h, w, d);
    chk(h == 1'b0, "R1 empty cache misses", 64'(h), 64'd0);
    chk(w == 3'd0, "R1 victim way 0 after reset", 64'(w), 64'd0);
  endtask

  task automatic t_fill_hit();
    logic h; logic [2:0] w; logic [15:0] d;
    do_fill(6'd5, 3'd3, 40'hA_BCDE_0001, 16'h1234, 1'b0);
    do_lookup(mk_va(36'h7, 6'd5, 6'd17), 40'hA_BCDE_0001, 0, h, w, d);
    chk(h == 1'b1, "R6 hit after fill", 64'(h), 64'd1);
    chk(w == 3'd3, "R6 hit way", 64'(w), 64'd3);
    chk(d == 16'h1234, "R10 payload returned", 64'(d), 64'h1234);
    do_lookup(mk_va(36'h7, 6'd5, 6'd17), 40'hA_BCDE_0000, 0, h, w, d);
    chk(h == 1'b0, "R3 other ppn misses", 64'(h), 64'd0);
    chk(w == 3'd0, "R7 lowest invalid victim", 64'(w), 64'd0);
    chk(d == 16'h0, "R7 miss payload zero", 64'(d), 64'd0);
  endtask

  task automatic t_index_source();
    logic h; logic [2:0] w; logic [15:0] d;
    do_lookup(mk_va(36'hF_FFFF_FFFF, 6'd5, 6'd63), 40'hA_BCDE_0001, 0, h, w, d);
    chk(h == 1'b1 && w == 3'd3, "R2 upper VA and offset ignored", {h, w}, {1'b1, 3'd3});
    do_lookup(mk_va(36'h7, 6'd6, 6'd17), 40'hA_BCDE_0001, 0, h, w, d);
    chk(h == 1'b0, "R2 R10 other set misses", 64'(h), 64'd0);
  endtask

  task automatic t_stall();
    logic h; logic [2:0] w; logic [15:0] d;
    do_lookup(mk_va(36'h3, 6'd5, 6'd0), 40'hA_BCDE_0001, 3, h, w, d);
    chk(h == 1'b1 && d == 16'h1234, "R5 late translation still hits", {h, d}, {1'b1, 16'h1234});
    @(negedge clk);
    chk(resp_valid == 1'b0, "R4 single-cycle response", 64'(resp_valid), 64'd0);
    chk(req_ready == 1'b1, "R5 ready after response", 64'(req_ready), 64'd1);
  endtask

  task automatic t_first_invalid();
    logic h; logic [2:0] w; logic [15:0] d;
    do_fill(6'd5, 3'd0, 40'h11, 16'h0011, 1'b0);
    do_fill(6'd5, 3'd1, 40'h22, 16'h0022, 1'b0);
    do_lookup(mk_va(36'h0, 6'd5, 6'd0), 40'h99, 0, h, w, d);
    chk(h == 1'b0 && w == 3'd2, "R7 skips valid ways", {h, w}, {1'b0, 3'd2});
  endtask

  task automatic t_round_robin();
    logic h; logic [2:0] w; logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      do_fill(6'd20, 3'(i), 40'h500 + 40'(i), 16'(i), 1'b0);
    end
    do_lookup(mk_va(36'h0, 6'd20, 6'd0), 40'h999, 0, h, w, d);
    chk(h == 1'b0 && w == 3'd0, "R8 full set uses pointer 0", {h, w}, {1'b0, 3'd0});
    do_fill(6'd20, 3'd0, 40'h777, 16'h0777, 1'b0);
    do_lookup(mk_va(36'h0, 6'd20, 6'd0), 40'h999, 0, h, w, d);
    chk(h == 1'b0 && w == 3'd1, "R8 pointer advanced", {h, w}, {1'b0, 3'd1});
    do_lookup(mk_va(36'h0, 6'd20, 6'd0), 40'h777, 0, h, w, d);
    chk(h == 1'b1 && w == 3'd0 && d == 16'h0777, "R10 refill replaces way", {h, w, d}, {1'b1, 3'd0, 16'h0777});
    for (int i = 0; i < 8; i++) begin
      do_fill(6'd21, 3'(i), 40'h600 + 40'(i), 16'(i), 1'b0);
    end
    do_lookup(mk_va(36'h0, 6'd21, 6'd0), 40'h999, 0, h, w, d);
    chk(h == 1'b0 && w == 3'd0, "R8 pointer is per set", {h, w}, {1'b0, 3'd0});
  endtask

  task automatic t_flush();
    logic h; logic [2:0] w; logic [15:0] d;
    do_flush();
    do_lookup(mk_va(36'h7, 6'd5, 6'd17), 40'hA_BCDE_0001, 0, h, w, d);
    chk(h == 1'b0 && w == 3'd0, "R9 flush invalidates", {h, w}, {1'b0, 3'd0});
    do_lookup(mk_va(36'h0, 6'd20, 6'd0), 40'h777, 0, h, w, d);
    chk(h == 1'b0, "R9 flush clears other sets", 64'(h), 64'd0);
    do_fill(6'd9, 3'd2, 40'h42, 16'h0042, 1'b1);
    do_lookup(mk_va(36'h0, 6'd9, 6'd0), 40'h42, 0, h, w, d);
    chk(h == 1'b0 && w == 3'd0, "R9 fill lost to flush", {h, w}, {1'b0, 3'd0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    xlat_valid = 1'b0; xlat_ppn = '0; fill_valid = 1'b0;
    fill_set = '0; fill_way = '0; fill_tag = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_index_source();
    t_stall();
    t_first_invalid();
    t_round_robin();
    t_flush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule